// File: doc/BRIEF.md
# Delta-Sigma Converter Result Reader

This block is the host side of a three-wire link to a 24-bit delta-sigma converter that shows its readiness on its data line. A start request drops chip select with the serial clock held low. The reader then samples the data line once per poll interval. A 1 means the converter is still busy. A 0 means a result is waiting. Once ready, the reader issues exactly 32 serial clock pulses and captures each bit on a rising edge, because the converter moves its data line on falling edges. The falling edge of the last pulse starts the converter's next conversion. The reader then raises chip select, which lets the converter sleep and keep its next result until the following read.

The 32-bit frame is split into four parts: the 24-bit result code, the sign flag, the extended-range flag and the 4 bits below the LSB. They are presented on a valid/ready output. If the always-zero dummy bit arrives as 1, a frame-error flag is raised. If readiness does not appear within a set number of system clocks, the poll is abandoned and a word with a timeout flag is presented instead. Parameters set the serial clock half-period, the poll interval and the timeout. A timeout of 0 turns the timeout off.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, chip select is high, the serial clock is low and no result is valid.
- R2: A start request taken while idle, with no result pending, drops chip select on the next clock.
- R3: While polling, the serial clock stays low and the data line is sampled every POLL_CLKS clocks. A sampled 1 keeps the reader polling. A sampled 0 starts the transfer.
- R4: A transfer issues exactly 32 rising serial clock edges with chip select low. Each high and low phase lasts HALF_CLKS clocks. The span from the first rising edge to chip select rising is 63*HALF_CLKS clocks.
- R5: Bits are captured on rising edges, first bit first. Frame bit 31 is end-of-conversion, bit 30 is the dummy, bit 29 is the sign flag and bit 28 is the extended-range flag. Bits 27..4 form the result code, MSB first, and bits 3..0 form the sub-LSB nibble.
- R6: Chip select rises on the clock of the 32nd falling serial edge, and the result becomes valid on that same clock.
- R7: The frame-error flag equals the received dummy bit (frame bit 30).
- R8: If the data line is still 1 at the sample taken when TIMEOUT_CLKS clocks of polling have elapsed, the reader raises chip select after exactly TIMEOUT_CLKS clocks of chip select low. It gives no serial clock pulse and presents a valid word with the timeout flag set and all data fields zero.
- R9: When a poll sample sees 0 on the same clock the timeout expires, the transfer proceeds and no timeout is reported.
- R10: While valid is high and ready is low, all output fields hold steady. Valid falls on the clock after ready is seen.
- R11: Start requests are ignored during a read and while a result is pending: each read produces exactly one chip select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion read |
| sdo_i | input | 1 | Converter serial data line |
| res_ready_i | input | 1 | Consumer accepts the presented word |
| cs_n_o | output | 1 | Converter chip select, active low |
| sck_o | output | 1 | Serial clock to the converter |
| res_valid_o | output | 1 | Presented word is valid |
| res_code_o | output | DATA_W | Result code |
| res_sign_o | output | 1 | Sign flag as received |
| res_ovr_o | output | 1 | Extended-range flag as received |
| res_sub_o | output | SUB_W | Sub-LSB nibble |
| res_frame_err_o | output | 1 | Dummy bit arrived as 1 |
| res_timeout_o | output | 1 | Poll abandoned on timeout |

## Verification
The readiness sample and the timeout expiry can fall on the same clock. With a poll interval of 4 and a timeout of 40, the tenth sample lands on the expiry clock. The converter model's busy time is set so that the line is still high at the ninth sample and low at the tenth, which must give a normal, complete read with no timeout. A busy time a few clocks longer must give a timeout after exactly 40 clocks of chip select low.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_POLL  = 2'd1,
      ST_SHIFT = 2'd2
   } rd_state_e;

   // status, dummy, sign and range bits ahead of the code
   localparam int unsigned HDR_BITS = 4;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   output logic tc
);
   localparam int unsigned W = adc_rd_pkg::cnt_width(LIMIT);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   logic [W-1:0] cnt_q;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("adc_rd_tick: LIMIT must be at least 1");
      end
   endgenerate

   assign tc = en && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (en)
         cnt_q <= tc ? '0 : cnt_q + 1'b1;
   end

   AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LAST); // R3

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
   parameter int unsigned FRAME_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               shift_en,
   input  logic               bit_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic               full_o
);
   localparam int unsigned CW = $clog2(FRAME_W + 1);
   localparam logic [CW-1:0] FULL = CW'(FRAME_W);

   logic [CW-1:0]      count_q;
   logic [FRAME_W-1:0] frame_q;

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("adc_rd_shift: FRAME_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         frame_q <= '0;
      end else if (clr) begin
         count_q <= '0;
         frame_q <= '0;
      end else if (shift_en) begin
         count_q <= count_q + 1'b1;
         frame_q <= {frame_q[FRAME_W-2:0], bit_i};
      end
   end

   assign frame_o = frame_q;
   assign full_o  = (count_q == FULL);

   AST_NO_EXTRA_BIT: assert property (@(posedge clk) disable iff (!rst_n) full_o |-> !shift_en); // R4
   AST_COUNT_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) count_q <= FULL);     // R4

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
   parameter int unsigned HALF_CLKS    = 2,
   parameter int unsigned POLL_CLKS    = 4,
   parameter int unsigned TIMEOUT_CLKS = 40,
   parameter int unsigned DATA_W       = 24,
   parameter int unsigned SUB_W        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              sdo_i,
   input  logic              res_ready_i,
   output logic              cs_n_o,
   output logic              sck_o,
   output logic              res_valid_o,
   output logic [DATA_W-1:0] res_code_o,
   output logic              res_sign_o,
   output logic              res_ovr_o,
   output logic [SUB_W-1:0]  res_sub_o,
   output logic              res_frame_err_o,
   output logic              res_timeout_o
);
   import adc_rd_pkg::*;

   localparam int unsigned FRAME_W  = HDR_BITS + DATA_W + SUB_W;
   localparam int unsigned POS_DMY  = FRAME_W - 2;
   localparam int unsigned POS_SIGN = FRAME_W - 3;
   localparam int unsigned POS_OVR  = FRAME_W - 4;

   generate
      if (HALF_CLKS < 1) begin : g_bad_half
         $error("adc_frame_reader: HALF_CLKS must be at least 1");
      end
      if (POLL_CLKS < 1) begin : g_bad_poll
         $error("adc_frame_reader: POLL_CLKS must be at least 1");
      end
      if (DATA_W < 1 || SUB_W < 1) begin : g_bad_fields
         $error("adc_frame_reader: DATA_W and SUB_W must be at least 1");
      end
   endgenerate

   rd_state_e          state_q;
   logic               cs_n_q, sck_q, valid_q;
   logic [DATA_W-1:0]  code_q;
   logic [SUB_W-1:0]   sub_q;
   logic               sign_q, ovr_q, ferr_q, tout_q;

   logic               in_poll, in_shift;
   logic               poll_tc, half_tc, tout_tc;
   logic               rise_ev, start_ok, ready_seen;
   logic [FRAME_W-1:0] frame_w;
   logic               frame_full;

   assign in_poll  = (state_q == ST_POLL);
   assign in_shift = (state_q == ST_SHIFT);

   adc_rd_tick #(.LIMIT(POLL_CLKS)) i_poll_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_poll),
      .clr   (!in_poll),
      .tc    (poll_tc)
   );

   adc_rd_tick #(.LIMIT(HALF_CLKS)) i_half_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_shift),
      .clr   (!in_shift),
      .tc    (half_tc)
   );

   generate
      if (TIMEOUT_CLKS > 0) begin : g_tout
         adc_rd_tick #(.LIMIT(TIMEOUT_CLKS)) i_tout_tick (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_poll),
            .clr   (!in_poll),
            .tc    (tout_tc)
         );
      end else begin : g_no_tout
         assign tout_tc = 1'b0;
      end
   endgenerate

   assign rise_ev    = in_shift && half_tc && !sck_q;
   assign ready_seen = poll_tc && !sdo_i;
   assign start_ok   = (state_q == ST_IDLE) && start_i && !valid_q;

   adc_rd_shift #(.FRAME_W(FRAME_W)) i_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (in_poll),
      .shift_en (rise_ev),
      .bit_i    (sdo_i),
      .frame_o  (frame_w),
      .full_o   (frame_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cs_n_q  <= 1'b1;
         sck_q   <= 1'b0;
         valid_q <= 1'b0;
         code_q  <= '0;
         sign_q  <= 1'b0;
         ovr_q   <= 1'b0;
         sub_q   <= '0;
         ferr_q  <= 1'b0;
         tout_q  <= 1'b0;
      end else begin
         if (valid_q && res_ready_i)
            valid_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  state_q <= ST_POLL;
                  cs_n_q  <= 1'b0;
               end
            end
            ST_POLL: begin
               if (ready_seen) begin
                  state_q <= ST_SHIFT;
               end else if (tout_tc) begin
                  state_q <= ST_IDLE;
                  cs_n_q  <= 1'b1;
                  valid_q <= 1'b1;
                  code_q  <= '0;
                  sign_q  <= 1'b0;
                  ovr_q   <= 1'b0;
                  sub_q   <= '0;
                  ferr_q  <= 1'b0;
                  tout_q  <= 1'b1;
               end
            end
            ST_SHIFT: begin
               if (half_tc) begin
                  sck_q <= ~sck_q;
                  if (sck_q && frame_full) begin
                     state_q <= ST_IDLE;
                     cs_n_q  <= 1'b1;
                     valid_q <= 1'b1;
                     code_q  <= frame_w[SUB_W +: DATA_W];
                     sign_q  <= frame_w[POS_SIGN];
                     ovr_q   <= frame_w[POS_OVR];
                     sub_q   <= frame_w[SUB_W-1:0];
                     ferr_q  <= frame_w[POS_DMY];
                     tout_q  <= 1'b0;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n_o          = cs_n_q;
   assign sck_o           = sck_q;
   assign res_valid_o     = valid_q;
   assign res_code_o      = code_q;
   assign res_sign_o      = sign_q;
   assign res_ovr_o       = ovr_q;
   assign res_sub_o       = sub_q;
   assign res_frame_err_o = ferr_q;
   assign res_timeout_o   = tout_q;

   AST_IDLE_CS_HIGH:    assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE) |-> (cs_n_q && !sck_q)); // R1
   AST_START_LOWERS_CS: assert property (@(posedge clk) disable iff (!rst_n) start_ok |=> !cs_n_q); // R2
   AST_SCK_LOW_POLL:    assert property (@(posedge clk) disable iff (!rst_n) in_poll |-> !sck_q); // R3
   AST_SCK_NEEDS_CS:    assert property (@(posedge clk) disable iff (!rst_n) sck_q |-> !cs_n_q); // R4
   AST_CS_RISE_VALID:   assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n_q) |-> valid_q); // R6
   AST_FERR_NOT_TOUT:   assert property (@(posedge clk) disable iff (!rst_n) (valid_q && ferr_q) |-> !tout_q); // R7
   AST_TOUT_FROM_POLL:  assert property (@(posedge clk) disable iff (!rst_n) $rose(tout_q) |-> $past(in_poll)); // R8
   AST_HOLD_STABLE:     assert property (@(posedge clk) disable iff (!rst_n)
                           (valid_q && !res_ready_i) |=> (valid_q && $stable(code_q) && $stable(sub_q) &&
                           $stable(sign_q) && $stable(ovr_q) && $stable(ferr_q) && $stable(tout_q))); // R10
   AST_VALID_DROP:      assert property (@(posedge clk) disable iff (!rst_n) (valid_q && res_ready_i) |=> !valid_q); // R10
   AST_NO_START_PEND:   assert property (@(posedge clk) disable iff (!rst_n) valid_q |=> cs_n_q); // R11

endmodule

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;
   localparam int HALF = 2;
   localparam int POLL = 4;
   localparam int TOUT = 40;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ready = 1'b0;
   wire  sdo;
   logic cs_n_o, sck_o, res_valid_o, res_sign_o, res_ovr_o, res_frame_err_o, res_timeout_o;
   logic [23:0] res_code_o;
   logic [3:0]  res_sub_o;

   int checks = 0, failures = 0;

   always #5 clk = ~clk;

   adc_frame_reader #(.HALF_CLKS(HALF), .POLL_CLKS(POLL), .TIMEOUT_CLKS(TOUT)) i_adc_frame_reader (
      .clk(clk), .rst_n(rst_n), .start_i(start), .sdo_i(sdo), .res_ready_i(ready),
      .cs_n_o(cs_n_o), .sck_o(sck_o), .res_valid_o(res_valid_o), .res_code_o(res_code_o),
      .res_sign_o(res_sign_o), .res_ovr_o(res_ovr_o), .res_sub_o(res_sub_o),
      .res_frame_err_o(res_frame_err_o), .res_timeout_o(res_timeout_o)
   );

   // converter model: busy while conv_left > 0, shifts on detected falling edges
   logic        ld_req = 1'b0;
   int          ld_conv = 0;
   logic [31:0] ld_frame = '0;
   int          conv_left = 0;
   int          m_idx = 0;
   logic [31:0] m_frame = '0;
   logic        m_prev_sck = 1'b0;

   always @(posedge clk) begin
      m_prev_sck <= sck_o;
      if (ld_req) begin
         conv_left <= ld_conv;
         m_frame   <= ld_frame;
         m_idx     <= 0;
      end else begin
         if (conv_left != 0) conv_left <= conv_left - 1;
         if (m_prev_sck && !sck_o) begin
            if (m_idx == 31) begin
               m_idx     <= 0;
               conv_left <= 1000;
            end else begin
               m_idx <= m_idx + 1;
            end
         end
      end
   end

   assign sdo = (cs_n_o || conv_left != 0) ? 1'b1 : m_frame[31 - m_idx];

   // port monitor
   int   rises = 0, span = 0, span_fin = 0, cs_low_len = 0, cs_falls = 0;
   logic span_on = 1'b0, mon_sck = 1'b0, mon_cs = 1'b1;

   always @(negedge clk) begin
      if (!cs_n_o && mon_cs) begin
         cs_falls++;
         rises = 0;
         span_on = 1'b0;
         cs_low_len = 1;
      end else if (!cs_n_o) begin
         cs_low_len++;
      end
      if (span_on) span++;
      if (sck_o && !mon_sck) begin
         if (rises == 0) begin
            span = 0;
            span_on = 1'b1;
         end
         rises++;
      end
      if (cs_n_o && !mon_cs && span_on) begin
         span_on = 1'b0;
         span_fin = span;
      end
      mon_sck = sck_o;
      mon_cs  = cs_n_o;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_read(input int conv, input logic [31:0] frame, input bit exp_tout,
                          input bit hold_start, input string tag);
      int falls0;
      int waited;
      logic [23:0] code_snap;
      falls0 = cs_falls;
      @(negedge clk);
      ld_req = 1'b1; ld_conv = conv; ld_frame = frame; start = 1'b1;
      @(negedge clk);
      ld_req = 1'b0;
      if (!hold_start) start = 1'b0;
      chk({tag, " R2 cs low after start"}, cs_n_o, 1'b0);
      waited = 0;
      while (!res_valid_o && waited < 5000) begin
         @(negedge clk);
         waited++;
      end
      chk({tag, " R6 valid seen"}, res_valid_o, 1'b1);
      chk({tag, " R6 cs high with valid"}, cs_n_o, 1'b1);
      @(negedge clk);
      if (exp_tout) begin
         chk({tag, " R8 timeout flag"}, res_timeout_o, 1'b1);
         chk({tag, " R8 no sck pulse"}, rises, 0);
         chk({tag, " R8 cs low length"}, cs_low_len, TOUT);
         chk({tag, " R8 code zero"}, res_code_o, 24'h0);
      end else begin
         chk({tag, " R5 code"}, res_code_o, frame[27:4]);
         chk({tag, " R5 sign"}, res_sign_o, frame[29]);
         chk({tag, " R5 ovr"}, res_ovr_o, frame[28]);
         chk({tag, " R5 sub"}, res_sub_o, frame[3:0]);
         chk({tag, " R7 frame err"}, res_frame_err_o, frame[30]);
         chk({tag, " R9 no timeout"}, res_timeout_o, 1'b0);
         chk({tag, " R4 rising edges"}, rises, 32);
         chk({tag, " R4 span"}, span_fin, 63 * HALF);
      end
      // R10/R11: back-pressure with start held high
      code_snap = res_code_o;
      start = 1'b1;
      repeat (4) @(negedge clk);
      chk({tag, " R10 valid held"}, res_valid_o, 1'b1);
      chk({tag, " R10 code stable"}, res_code_o, code_snap);
      chk({tag, " R11 cs stays high"}, cs_n_o, 1'b1);
      start = 1'b0;
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      chk({tag, " R10 valid drops"}, res_valid_o, 1'b0);
      chk({tag, " R11 one cs fall"}, cs_falls - falls0, 1);
      @(negedge clk);
   endtask

   function automatic logic [31:0] mk(input bit dmy, input bit sg, input bit ex,
                                      input logic [23:0] code, input logic [3:0] sub);
      return {1'b0, dmy, sg, ex, code, sub};
   endfunction

   initial begin
      #10000000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset cs", cs_n_o, 1'b1);
      chk("R1 reset sck", sck_o, 1'b0);
      chk("R1 reset valid", res_valid_o, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle cs", cs_n_o, 1'b1);

      for (int i = 0; i < 24; i++)
         do_read((i % 5) * 7, mk(1'b0, i[0], i[1], 24'h1 << i, i[3:0]), 1'b0, 1'b0, "R5 walk");
      do_read(0,  mk(1'b0, 1'b1, 1'b1, 24'hFFFFFF, 4'hF), 1'b0, 1'b0, "R5 ones");
      do_read(3,  mk(1'b0, 1'b0, 1'b0, 24'h000000, 4'h0), 1'b0, 1'b0, "R5 zeros");
      do_read(20, mk(1'b0, 1'b1, 1'b0, 24'hA5C3_3C, 4'h9), 1'b0, 1'b1, "R11 busy start");
      do_read(10, mk(1'b1, 1'b0, 1'b1, 24'h5A5A5A, 4'h6), 1'b0, 1'b0, "R7 dummy");
      do_read(35, mk(1'b0, 1'b1, 1'b0, 24'h123456, 4'h3), 1'b0, 1'b0, "R3 long poll");
      do_read(38, mk(1'b0, 1'b0, 1'b1, 24'h654321, 4'hC), 1'b0, 1'b0, "R9 coincide");
      do_read(42, mk(1'b0, 1'b1, 1'b1, 24'h777777, 4'h1), 1'b1, 1'b0, "R8 timeout");
      do_read(5000, mk(1'b0, 1'b1, 1'b1, 24'h888888, 4'h2), 1'b1, 1'b0, "R8 stuck busy");
      do_read(1,  mk(1'b0, 1'b0, 1'b0, 24'hC0FFEE, 4'hE), 1'b0, 1'b0, "R3 after timeout");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule